// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects up to 128 level-sensitive interrupt lines, grouped in banks of 32, into one processor interrupt request. Software programs it over a simple single-cycle 32-bit register bus. Each source has its own mask bit, which can be written directly or changed through write-one-to-set and write-one-to-clear aliases. Each source also has an 8-bit level register whose upper six bits give its priority. A global threshold can hold back sources that are not urgent enough.

A small sequencer controls the output. In state ST_IDLE it waits for an eligible source. Transition T_SELECT latches the winning source number and enters ST_ACTIVE, where the interrupt output is high. Transition T_ACK is taken when software writes the acknowledge bit, and leads to ST_GAP, a one-cycle state with the output low. Transition T_REARM then returns the sequencer to ST_IDLE. Transition T_CLEAR is taken when a soft reset is applied, and forces ST_IDLE from any state. A soft reset takes one cycle. During that cycle the status register reports the reset as not yet done. On the following edge all programmable state returns to its reset values.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, irq_o is 0. Every mask bit is 1, so each bank's mask register reads 0xFFFFFFFF. Every level register reads 0 and the threshold reads 0xFF. The sorted register reads 0x80, and status bit 0 at 0x014 reads 1.
- R2: The register at 0x000 reads the major version in bits 7:4 and the minor version in bits 3:0 (0x21 by default). Sysconfig at 0x010 stores autoidle in bit 0. Protection at 0x04C stores bit 0. Idle at 0x050 stores bits 1:0. Threshold at 0x068 stores bits 7:0.
- R3: For bank b, the mask register is at 0x084+0x20*b and takes a full write. A 1 written to 0x088+0x20*b clears that mask bit, which enables the source. A 1 written to 0x08C+0x20*b sets that mask bit. Bits written as 0 to either alias leave the mask unchanged. Mask bit k of bank b covers source 32*b+k.
- R4: The pending register at 0x098+0x20*b reads the bank's source inputs ANDed with the inverse of its mask, so a masked source reads 0.
- R5: Source i has a level register at 0x100+4*i. Its priority is bits 7:2, and 0 is the most urgent.
- R6: In ST_IDLE, the unmasked asserted source with the lowest priority value wins, and a tie goes to the lower source number. One clock edge later, irq_o is 1 and the sorted register at 0x040 reads the source number in bits 6:0, with bit 7 at 0. While no interrupt is active, the sorted register reads 0x80.
- R7: While irq_o is 1, it stays 1 and the sorted number does not change until an acknowledge, even when a more urgent source arrives.
- R8: Writing 1 to bit 0 of 0x048 acknowledges the interrupt. irq_o is 0 after that edge and stays 0 for the next edge as well. The acknowledge clears the active state even if the active source has since been masked or removed.
- R9: A source can win only if the threshold is 0xFF or its priority, zero-extended to 8 bits, is strictly less than the threshold.
- R10: Writing sysconfig with bit 1 set starts a soft reset. After that edge, status bit 0 reads 0. After the next edge, status bit 0 reads 1 and all state is back to the R1 values, including sysconfig, with irq_o at 0. Sysconfig bit 1 always reads 0.
- R11: NUM_SRC is 96 or 128. Bank and level addresses beyond NUM_SRC read 0, and the highest source, NUM_SRC-1, can be selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, taken on the rising edge |
| bus_addr | input | 12 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| src_lvl | input | NUM_SRC | Level-sensitive interrupt source lines |
| irq_o | output | 1 | Processor interrupt request |

## Verification
A source asserted before a clock edge shows up on irq_o and in the sorted register after exactly one edge. The bench therefore drives stimulus on a falling edge and checks on the very next falling edge. After an acknowledge write, irq_o is low following the write edge and stays low for one more edge, and a still-pending source reappears on the third falling edge; the bench samples each of those three points. Register reads are combinational, so the bench reads them 1 ns after setting the address. A soft reset is checked in two steps: the status bit is 0 after the write edge and all values are restored one edge later.

// File: rtl/intc_pkg.sv
package intc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_GAP    = 2'd2
    } seq_state_t;

    localparam logic [11:0] A_REV     = 12'h000;
    localparam logic [11:0] A_SYSCFG  = 12'h010;
    localparam logic [11:0] A_SYSSTAT = 12'h014;
    localparam logic [11:0] A_SORTED  = 12'h040;
    localparam logic [11:0] A_CTRL    = 12'h048;
    localparam logic [11:0] A_PROT    = 12'h04C;
    localparam logic [11:0] A_IDLE    = 12'h050;
    localparam logic [11:0] A_THR     = 12'h068;
    localparam logic [11:0] A_BANK0   = 12'h080;
    localparam logic [11:0] A_LVL0    = 12'h100;

    localparam logic [4:0] SUB_MASK = 5'h04;
    localparam logic [4:0] SUB_MCLR = 5'h08;
    localparam logic [4:0] SUB_MSET = 5'h0C;
    localparam logic [4:0] SUB_PEND = 5'h18;

    localparam int PRIO_W = 6;
    localparam int BANK_W = 32;
endpackage

// File: rtl/intc_prio_pick.sv
module intc_prio_pick
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 96,
    parameter int IDW     = 7
) (
    input  logic [NUM_SRC-1:0]             req,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
    output logic                           found,
    output logic [IDW-1:0]                 id,
    output logic [PRIO_W-1:0]              best
);
    // Walk from the top index down; "<=" lets a lower index take a tie.
    always_comb begin
        found = 1'b0;
        id    = '0;
        best  = '1;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i] && (!found || prio[i] <= best)) begin
                found = 1'b1;
                id    = IDW'(i);
                best  = prio[i];
            end
        end
    end
endmodule

// File: rtl/intc_seq_fsm.sv
module intc_seq_fsm
    import intc_pkg::*;
#(
    parameter int IDW = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           win_ok,
    input  logic [IDW-1:0] win_id,
    input  logic           ack,
    output logic           irq_o,
    output logic [IDW-1:0] act_id
);
    seq_state_t state_q, state_d;
    logic [IDW-1:0] id_q;

    // state register and latched source number
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            id_q    <= '0;
        end else begin
            state_q <= state_d;
            if (!clr && state_q == ST_IDLE && win_ok)
                id_q <= win_id;
        end
    end

    // transitions T_SELECT, T_ACK, T_REARM, T_CLEAR
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (win_ok) state_d = ST_ACTIVE;
            ST_ACTIVE: if (ack)    state_d = ST_GAP;
            ST_GAP:                state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
        if (clr)
            state_d = ST_IDLE;
    end

    // outputs
    always_comb begin
        irq_o  = (state_q == ST_ACTIVE);
        act_id = id_q;
    end

    // R7
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack && !clr) |=> (irq_o && $stable(act_id)));

    // R8
    ack_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && ack) |=> !irq_o);
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import intc_pkg::*;
#(
    parameter int           NUM_SRC   = 96,
    parameter logic [3:0]   REV_MAJOR = 4'd2,
    parameter logic [3:0]   REV_MINOR = 4'd1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [11:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] src_lvl,
    output logic               irq_o
);
    localparam int NBANK = NUM_SRC / BANK_W;
    localparam int IDW   = $clog2(NUM_SRC);
    localparam int BKW   = $clog2(NBANK);

    if (NUM_SRC != 96 && NUM_SRC != 128) begin : g_bad_size
        $error("NUM_SRC must be 96 or 128");
    end

    logic                 srst_pend;
    logic                 autoidle_q;
    logic                 prot_q;
    logic [1:0]           idle_q;
    logic [7:0]           thr_q;
    logic [31:0]          mask_b [NBANK];
    logic [NUM_SRC-1:0]   mask_q;
    logic [7:0]           lvl_q  [NUM_SRC];
    logic [NUM_SRC-1:0][PRIO_W-1:0] prio_v;
    logic [NUM_SRC-1:0]   pend, pend_d;
    logic                 found, win_ok;
    logic [IDW-1:0]       win_id, act_id;
    logic [PRIO_W-1:0]    best;

    // address decode
    logic           wr_ok, ack;
    logic [6:0]     bk_full;
    logic           in_bank, in_lvl;
    logic [BKW-1:0] bk_sel;
    logic [4:0]     sub;
    logic [9:0]     lvl_w;
    logic [IDW-1:0] li;

    assign wr_ok   = bus_wr && !srst_pend;
    assign bk_full = bus_addr[11:5] - A_BANK0[11:5];
    assign in_bank = (bus_addr[11:5] >= A_BANK0[11:5]) && (bk_full < 7'(NBANK));
    assign bk_sel  = bk_full[BKW-1:0];
    assign sub     = bus_addr[4:0];
    assign lvl_w   = bus_addr[11:2] - A_LVL0[11:2];
    assign in_lvl  = (bus_addr >= A_LVL0) && (lvl_w < 10'(NUM_SRC)) && (bus_addr[1:0] == 2'b00);
    assign li      = lvl_w[IDW-1:0];
    assign ack     = wr_ok && (bus_addr == A_CTRL) && bus_wdata[0];

    // scalar configuration registers and soft reset sequencing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            srst_pend  <= 1'b0;
            autoidle_q <= 1'b0;
            prot_q     <= 1'b0;
            idle_q     <= 2'b00;
            thr_q      <= 8'hFF;
        end else if (srst_pend) begin
            srst_pend  <= 1'b0;
            autoidle_q <= 1'b0;
            prot_q     <= 1'b0;
            idle_q     <= 2'b00;
            thr_q      <= 8'hFF;
        end else if (wr_ok) begin
            unique case (bus_addr)
                A_SYSCFG: begin
                    autoidle_q <= bus_wdata[0];
                    srst_pend  <= bus_wdata[1];
                end
                A_PROT:  prot_q <= bus_wdata[0];
                A_IDLE:  idle_q <= bus_wdata[1:0];
                A_THR:   thr_q  <= bus_wdata[7:0];
                default: ;
            endcase
        end
    end

    // per-bank mask with direct, set and clear writes
    for (genvar gb = 0; gb < NBANK; gb++) begin : g_bank
        logic hit;
        assign hit = wr_ok && in_bank && (bk_sel == BKW'(gb));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mask_b[gb] <= '1;
            else if (srst_pend)
                mask_b[gb] <= '1;
            else if (hit) begin
                if (sub == SUB_MASK) mask_b[gb] <= bus_wdata;
                if (sub == SUB_MCLR) mask_b[gb] <= mask_b[gb] & ~bus_wdata;
                if (sub == SUB_MSET) mask_b[gb] <= mask_b[gb] | bus_wdata;
            end
        end
        assign mask_q[gb*BANK_W +: BANK_W] = mask_b[gb];
    end

    // per-source level registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SRC; i++) lvl_q[i] <= '0;
        end else if (srst_pend) begin
            for (int i = 0; i < NUM_SRC; i++) lvl_q[i] <= '0;
        end else if (wr_ok && in_lvl) begin
            lvl_q[li] <= bus_wdata[7:0];
        end
    end

    for (genvar gs = 0; gs < NUM_SRC; gs++) begin : g_prio
        assign prio_v[gs] = lvl_q[gs][7:2];
    end

    assign pend = src_lvl & ~mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_d <= '0;
        else        pend_d <= pend;
    end

    intc_prio_pick #(.NUM_SRC(NUM_SRC), .IDW(IDW)) u_pick (
        .req   (pend),
        .prio  (prio_v),
        .found (found),
        .id    (win_id),
        .best  (best)
    );

    assign win_ok = found && ((thr_q == 8'hFF) || ({2'b00, best} < thr_q));

    intc_seq_fsm #(.IDW(IDW)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (srst_pend),
        .win_ok (win_ok),
        .win_id (win_id),
        .ack    (ack),
        .irq_o  (irq_o),
        .act_id (act_id)
    );

    // read path
    always_comb begin
        bus_rdata = '0;
        if (in_bank) begin
            if (sub == SUB_MASK) bus_rdata = mask_b[bk_sel];
            if (sub == SUB_PEND) bus_rdata = pend[bk_sel*BANK_W +: BANK_W];
        end else if (in_lvl) begin
            bus_rdata = {24'd0, lvl_q[li]};
        end else begin
            unique case (bus_addr)
                A_REV:     bus_rdata = {24'd0, REV_MAJOR, REV_MINOR};
                A_SYSCFG:  bus_rdata = {31'd0, autoidle_q};
                A_SYSSTAT: bus_rdata = {31'd0, !srst_pend};
                A_SORTED:  bus_rdata = irq_o ? {24'd0, 8'(act_id)} : 32'h80;
                A_PROT:    bus_rdata = {31'd0, prot_q};
                A_IDLE:    bus_rdata = {30'd0, idle_q};
                A_THR:     bus_rdata = {24'd0, thr_q};
                default:   bus_rdata = '0;
            endcase
        end
    end

    // R6
    pick_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> pend_d[act_id]);

    // R10
    srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst_pend |=> ((&mask_q) && !irq_o && (thr_q == 8'hFF)));

    // R11
    id_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (32'(act_id) < NUM_SRC));
endmodule

// File: tb/vec_irq_ctrl_test.sv
module vec_irq_ctrl_test;
    localparam int NS = 96;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NS-1:0] src = '0;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    vec_irq_ctrl #(.NUM_SRC(NS)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_lvl(src), .irq_o(irq)
    );

    always #10 clk = ~clk;

    // {src a, src b, src c, irq expected, number expected}; 127 = unused
    localparam logic [28:0] VEC [8] = '{
        {7'd33, 7'd127, 7'd127, 1'b1, 7'd33},
        {7'd5,  7'd33,  7'd127, 1'b1, 7'd5},
        {7'd5,  7'd40,  7'd90,  1'b1, 7'd40},
        {7'd70, 7'd40,  7'd127, 1'b1, 7'd40},
        {7'd90, 7'd70,  7'd127, 1'b1, 7'd70},
        {7'd127,7'd127, 7'd127, 1'b0, 7'd0},
        {7'd33, 7'd12,  7'd127, 1'b1, 7'd12},
        {7'd95, 7'd127, 7'd127, 1'b1, 7'd95}
    };

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rchk(input string tag, input string what,
                        input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, what, d, exp);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "irq", {31'd0, irq}, 32'd0);
        rchk("R1", "sysstatus", 12'h014, 32'd1);
        rchk("R1", "mask bank0", 12'h084, 32'hFFFF_FFFF);
        rchk("R1", "mask bank2", 12'h0C4, 32'hFFFF_FFFF);
        rchk("R1", "level 7", 12'h11C, 32'd0);
        rchk("R1", "threshold", 12'h068, 32'hFF);
        rchk("R1", "sorted idle", 12'h040, 32'h80);

        // R2 plain registers
        rchk("R2", "revision", 12'h000, 32'h21);
        wr(12'h04C, 32'h1);
        rchk("R2", "protection", 12'h04C, 32'h1);
        wr(12'h050, 32'h3);
        rchk("R2", "idle", 12'h050, 32'h3);

        // R11 out-of-range addresses
        rchk("R11", "bank3 pending", 12'h0F8, 32'd0);
        rchk("R11", "level 96", 12'h280, 32'd0);

        // R4 masked source is invisible
        src[3] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R4", "irq masked", {31'd0, irq}, 32'd0);
        rchk("R4", "pending masked", 12'h098, 32'd0);
        wr(12'h088, 32'h8);
        rchk("R4", "pending unmasked", 12'h098, 32'h8);
        @(negedge clk);
        chk("R6", "irq src3", {31'd0, irq}, 32'd1);
        rchk("R6", "sorted src3", 12'h040, 32'd3);
        src[3] = 1'b0;
        wr(12'h048, 32'h1);
        @(negedge clk);

        // R3 mask aliases
        wr(12'h08C, 32'h8);
        rchk("R3", "set alias", 12'h084, 32'hFFFF_FFFF);
        wr(12'h088, 32'h0);
        rchk("R3", "clear zeros", 12'h084, 32'hFFFF_FFFF);
        wr(12'h0A8, 32'h0000_00F0);
        rchk("R3", "bank1 clear", 12'h0A4, 32'hFFFF_FF0F);
        wr(12'h0AC, 32'h0000_0030);
        rchk("R3", "bank1 set", 12'h0A4, 32'hFFFF_FF3F);
        wr(12'h0A4, 32'h1234_5678);
        rchk("R3", "bank1 direct", 12'h0A4, 32'h1234_5678);

        // unmask all, program priorities
        wr(12'h084, 32'd0);
        wr(12'h0A4, 32'd0);
        wr(12'h0C4, 32'd0);
        for (int i = 0; i < NS; i++) wr(12'(12'h100 + 4 * i), 32'h28);
        wr(12'h114, 32'h0C);
        wr(12'h1A0, 32'h04);
        wr(12'h218, 32'h04);
        wr(12'h268, 32'h08);
        rchk("R5", "level 5", 12'h114, 32'h0C);
        rchk("R5", "level 90", 12'h268, 32'h08);

        // R6 vector table
        for (int v = 0; v < 8; v++) begin
            logic [28:0] e;
            logic [31:0] d;
            e = VEC[v];
            src = '0;
            if (e[28:22] < NS) src[e[28:22]] = 1'b1;
            if (e[21:15] < NS) src[e[21:15]] = 1'b1;
            if (e[14:8]  < NS) src[e[14:8]]  = 1'b1;
            @(negedge clk);
            chk("R6", "vector irq", {31'd0, irq}, {31'd0, e[7]});
            rd(12'h040, d);
            chk("R6", "vector sorted", d, e[7] ? {25'd0, e[6:0]} : 32'h80);
            src = '0;
            if (e[7]) begin
                wr(12'h048, 32'h1);
                chk("R8", "irq after ack", {31'd0, irq}, 32'd0);
            end
            @(negedge clk);
        end

        // R7 hold against a more urgent arrival
        src[33] = 1'b1;
        @(negedge clk);
        src[40] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R7", "irq held", {31'd0, irq}, 32'd1);
        rchk("R7", "sorted held", 12'h040, 32'd33);
        wr(12'h048, 32'h1);
        chk("R8", "gap cycle 1", {31'd0, irq}, 32'd0);
        @(negedge clk);
        chk("R8", "gap cycle 2", {31'd0, irq}, 32'd0);
        @(negedge clk);
        chk("R8", "reselect", {31'd0, irq}, 32'd1);
        rchk("R8", "reselect id", 12'h040, 32'd40);
        src = '0;
        wr(12'h048, 32'h1);
        @(negedge clk);

        // R8 stuck active: source masked while active
        src[33] = 1'b1;
        @(negedge clk);
        wr(12'h0AC, 32'h2);
        @(negedge clk);
        chk("R8", "irq while masked", {31'd0, irq}, 32'd1);
        rchk("R4", "pending after mask", 12'h0B8, 32'd0);
        wr(12'h048, 32'h1);
        repeat (2) @(negedge clk);
        chk("R8", "stuck cleared", {31'd0, irq}, 32'd0);
        rchk("R8", "sorted cleared", 12'h040, 32'h80);
        src = '0;
        wr(12'h0A8, 32'h2);

        // R9 threshold
        wr(12'h068, 32'h02);
        src[5] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9", "prio3 blocked thr2", {31'd0, irq}, 32'd0);
        src[40] = 1'b1;
        @(negedge clk);
        chk("R9", "prio1 passes thr2", {31'd0, irq}, 32'd1);
        rchk("R9", "sorted thr2", 12'h040, 32'd40);
        src[40] = 1'b0;
        wr(12'h068, 32'h03);
        wr(12'h048, 32'h1);
        repeat (2) @(negedge clk);
        chk("R9", "prio3 blocked thr3", {31'd0, irq}, 32'd0);
        wr(12'h068, 32'hFF);
        @(negedge clk);
        chk("R9", "thr disabled", {31'd0, irq}, 32'd1);
        rchk("R9", "sorted thr off", 12'h040, 32'd5);
        src = '0;
        wr(12'h048, 32'h1);
        @(negedge clk);

        // R10 soft reset while active
        src[33] = 1'b1;
        @(negedge clk);
        wr(12'h010, 32'h1);
        rchk("R2", "autoidle", 12'h010, 32'h1);
        wr(12'h010, 32'h3);
        rchk("R10", "status busy", 12'h014, 32'd0);
        @(negedge clk);
        rchk("R10", "status done", 12'h014, 32'd1);
        chk("R10", "irq cleared", {31'd0, irq}, 32'd0);
        rchk("R10", "mask restored", 12'h0A4, 32'hFFFF_FFFF);
        rchk("R10", "level cleared", 12'h1A0, 32'd0);
        rchk("R10", "threshold restored", 12'h068, 32'hFF);
        rchk("R10", "sysconfig cleared", 12'h010, 32'd0);
        rchk("R10", "protection cleared", 12'h04C, 32'd0);
        @(negedge clk);
        chk("R10", "masked after reset", {31'd0, irq}, 32'd0);
        src = '0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule